// File: doc/BRIEF.md
# Nested Priority Event Controller

This block arbitrates sixteen core event levels for a processor core. Level 0 has the highest priority and level 15 the lowest. The levels are assigned as follows:

- 0: emulation
- 1: reset
- 2: non-maskable interrupt
- 3: exception
- 4: reserved
- 5: hardware error
- 6: core timer
- 7 to 15: general-purpose

Requests reach a level in one of four ways:

- a direct core request line;
- a system source, steered to a general-purpose level through a writable routing table;
- the exception port;
- a software raise request.

Each request sets a pending bit. Every cycle the block takes the best pending event that is enabled, may preempt the handlers in service, and sends the fetch path to that level's vector.

When an event is taken, the block saves a return address into one of four return registers. The register used depends on the event class: emulation, non-maskable, exception or interrupt. For an exception, the saved address is chosen by whether the exception is a service exception or an error exception. A return request ends the highest-priority handler in service. It sends the fetch path back to the address held for that handler's class.

An in-service vector and a supervisor flag report the nesting state.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After synchronous reset:
  - nothing is pending or in service;
  - `redir_valid` and `supervisor` are 0;
  - every maskable level (5 to 15) is disabled;
  - the routing table holds its default assignment.
- R2: The block takes the lowest-numbered level that is pending and enabled. A request sampled at clock edge N causes a take at edge N+1. After that edge, `redir_valid` is 1 for one cycle, with `redir_lvl` set to the level and `redir_addr` set to that level's vector.
- R3: Bit k of `mask_wdata`, written with `mask_we`, enables level k for k = 5 to 15. Levels 0 to 3 are always enabled. A masked request stays pending and is taken once its level is enabled.
- R4: Level 4 never becomes pending. Bit 3 of `core_req` has no effect: level 3 is requested only through `exc_req`. A raise request for level 3 or level 4 is ignored.
- R5: A pending event is taken only if its level number is lower than every level in service. A taken event sets its `in_service` bit.
- R6: When at least one level is in service, `rtn_req` clears the lowest-numbered in-service bit. On the next cycle it produces a redirect to a return register chosen by that level: level 0 uses the emulation register, 2 the non-maskable register, 3 the exception register, and all other levels the interrupt register. When no level is in service, `rtn_req` is ignored. A return has priority over a take in the same cycle.
- R7: Taking level 0, 2 or 5 to 15 stores `cur_pc` into that class's return register. Taking level 1 stores nothing.
- R8: On `exc_req`, the block latches a return address: `exc_next_pc` when `exc_service` is 1, and `exc_pc` when it is 0. Taking level 3 copies that latched value into the exception register.
- R9: System source s raises level 7 + g, where g is the routing entry of s. A write with `route_we` sets entry `route_src` to `route_gp`. A value of g above 8 disconnects the source.
  - Default entries: sources 0-6 → g 0, 7-8 → 1, 9-12 → 2, 13-15 → 3, 16-18 → 4, 19-20 → 5, 21-23 → 6.
- R10: `raise_req` sets the pending bit of `raise_lvl`, exactly as a hardware request does.
- R11: `supervisor` is 1 exactly while any bit of `in_service` is set. It can only rise together with a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 16 | Direct request per level (bits 3 and 4 unused) |
| sys_req | input | NUM_SRC | System source requests |
| route_we | input | 1 | Routing table write strobe |
| route_src | input | SRCW | Routing entry to write |
| route_gp | input | 4 | General-purpose index (level 7+g); a value above 8 disconnects |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | 16 | Per-level enable bits |
| vec_we | input | 1 | Vector table write strobe |
| vec_lvl | input | 4 | Vector table entry to write |
| vec_wdata | input | AW | Vector address |
| raise_req | input | 1 | Software raise strobe |
| raise_lvl | input | 4 | Level to raise |
| exc_req | input | 1 | Exception request |
| exc_service | input | 1 | 1 = service exception, 0 = error exception |
| exc_pc | input | AW | Address of the excepting instruction |
| exc_next_pc | input | AW | Address of the instruction after it |
| cur_pc | input | AW | Address to resume an interrupted flow |
| rtn_req | input | 1 | Return from the current handler |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | AW | Redirect target |
| redir_lvl | output | 4 | Level taken or returned from |
| in_service | output | 16 | Levels whose handlers are in service |
| supervisor | output | 1 | A handler is running |

## Verification
The bench uses AW = 16 and keeps NUM_SRC at its default of 24. With 24 sources, every default routing group, from the error group (g 0) through the memory-transfer and watchdog group (g 6), has at least one source that the bench can drive. The 16-bit addresses keep the vector and return values easy to tell apart. They also leave room for distinct `exc_pc` and `exc_next_pc` values, so a wrong choice between service and error return addresses is visible.

With sixteen levels, the bench can build a three-deep nesting chain: timer, then non-maskable, then unwinding back to a deferred general-purpose level. It can also test a disconnecting routing value (g = 12).

// File: rtl/nest_evt_pkg.sv
package nest_evt_pkg;

    localparam int NLVL    = 16;
    localparam int LVLW    = 4;
    localparam int NGP     = 9;
    localparam int GP_BASE = 7;

    localparam logic [NLVL-1:0] MASKABLE = 16'hFFE0;
    localparam logic [NLVL-1:0] NO_HW    = 16'h0018;

    localparam logic [LVLW-1:0] LVL_RST = 4'd1;
    localparam logic [LVLW-1:0] LVL_EXC = 4'd3;
    localparam logic [LVLW-1:0] LVL_RSV = 4'd4;

    typedef logic [LVLW-1:0] lvl_t;

    typedef enum logic [1:0] {RC_INT, RC_EXC, RC_NMI, RC_EMU} rcls_e;

    typedef struct packed {
        logic vld;
        lvl_t lvl;
    } pick_t;

    // Map a level to the return register class it uses.
    function automatic rcls_e cls_of(lvl_t l);
        case (l)
            4'd0:    return RC_EMU;
            4'd2:    return RC_NMI;
            4'd3:    return RC_EXC;
            default: return RC_INT;
        endcase
    endfunction

    // Default general-purpose group for each system source.
    function automatic logic [3:0] dflt_gp(int s);
        if (s < 7)  return 4'd0;
        if (s < 9)  return 4'd1;
        if (s < 13) return 4'd2;
        if (s < 16) return 4'd3;
        if (s < 19) return 4'd4;
        if (s < 21) return 4'd5;
        if (s < 24) return 4'd6;
        return 4'd8;
    endfunction

endpackage

// File: rtl/nest_evt_route.sv
module nest_evt_route
    import nest_evt_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int SRCW    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SRCW-1:0]    src,
    input  logic [3:0]         gp,
    input  logic [NUM_SRC-1:0] sys_req,
    output logic [NLVL-1:0]    lvl_req
);

    logic [3:0] map_q [NUM_SRC];

    // One routing entry per system source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[s] <= dflt_gp(s);
            end else if (we && int'(src) == s) begin
                map_q[s] <= gp;
            end
        end
    end

    // OR every active source onto its general-purpose level.
    always_comb begin
        lvl_req = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (sys_req[s] && map_q[s] < 4'(NGP)) begin
                lvl_req[GP_BASE + int'(map_q[s])] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nest_evt_pick.sv
module nest_evt_pick
    import nest_evt_pkg::*;
(
    input  logic [NLVL-1:0] cand,
    input  logic [NLVL-1:0] act,
    output pick_t           pick,
    output logic            act_any,
    output lvl_t            act_min
);

    logic cany;
    lvl_t cmin;

    always_comb begin
        cany    = 1'b0;
        cmin    = '0;
        act_any = 1'b0;
        act_min = '0;

        // Scan downwards so the lowest-numbered set bit wins.
        for (int l = NLVL - 1; l >= 0; l--) begin
            if (cand[l]) begin
                cany = 1'b1;
                cmin = lvl_t'(l);
            end
            if (act[l]) begin
                act_any = 1'b1;
                act_min = lvl_t'(l);
            end
        end

        pick.vld = cany && (!act_any || cmin < act_min);
        pick.lvl = cmin;
    end

endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
    import nest_evt_pkg::*;
#(
    parameter  int AW      = 32,
    parameter  int NUM_SRC = 24,
    localparam int SRCW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        core_req,
    input  logic [NUM_SRC-1:0] sys_req,
    input  logic               route_we,
    input  logic [SRCW-1:0]    route_src,
    input  logic [3:0]         route_gp,
    input  logic               mask_we,
    input  logic [15:0]        mask_wdata,
    input  logic               vec_we,
    input  logic [3:0]         vec_lvl,
    input  logic [AW-1:0]      vec_wdata,
    input  logic               raise_req,
    input  logic [3:0]         raise_lvl,
    input  logic               exc_req,
    input  logic               exc_service,
    input  logic [AW-1:0]      exc_pc,
    input  logic [AW-1:0]      exc_next_pc,
    input  logic [AW-1:0]      cur_pc,
    input  logic               rtn_req,
    output logic               redir_valid,
    output logic [AW-1:0]      redir_addr,
    output logic [3:0]         redir_lvl,
    output logic [15:0]        in_service,
    output logic               supervisor
);

    logic [NLVL-1:0] pend_q, act_q, mask_q;
    logic [NLVL-1:0] route_req, raise_oh, new_req, enab, take_oh;
    logic [AW-1:0]   vec_q [NLVL];
    logic [AW-1:0]   reti_q, retx_q, retn_q, rete_q, exc_ret_q, ret_addr;
    pick_t           pick;
    logic            act_any, do_ret, do_take;
    lvl_t            act_min;

    nest_evt_route #(.NUM_SRC(NUM_SRC), .SRCW(SRCW)) i_route (
        .clk     (clk),
        .rst     (rst),
        .we      (route_we),
        .src     (route_src),
        .gp      (route_gp),
        .sys_req (sys_req),
        .lvl_req (route_req)
    );

    nest_evt_pick i_pick (
        .cand    (enab),
        .act     (act_q),
        .pick    (pick),
        .act_any (act_any),
        .act_min (act_min)
    );

    // Vector table, one entry per level.
    for (genvar l = 0; l < NLVL; l++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[l] <= '0;
            end else if (vec_we && vec_lvl == lvl_t'(l)) begin
                vec_q[l] <= vec_wdata;
            end
        end
    end

    always_comb begin
        raise_oh = '0;
        if (raise_req && raise_lvl != LVL_EXC && raise_lvl != LVL_RSV) begin
            raise_oh[raise_lvl] = 1'b1;
        end

        new_req          = (core_req & ~NO_HW) | route_req | raise_oh;
        new_req[LVL_EXC] = new_req[LVL_EXC] | exc_req;

        enab    = pend_q & (~MASKABLE | mask_q);
        do_ret  = rtn_req && act_any;
        do_take = !do_ret && pick.vld;
        take_oh = do_take ? (NLVL'(1) << pick.lvl) : '0;

        case (cls_of(act_min))
            RC_EMU:  ret_addr = rete_q;
            RC_NMI:  ret_addr = retn_q;
            RC_EXC:  ret_addr = retx_q;
            default: ret_addr = reti_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            act_q       <= '0;
            mask_q      <= '0;
            reti_q      <= '0;
            retx_q      <= '0;
            retn_q      <= '0;
            rete_q      <= '0;
            exc_ret_q   <= '0;
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            redir_lvl   <= '0;
        end else begin
            pend_q      <= (pend_q & ~take_oh) | new_req;
            redir_valid <= do_ret | do_take;

            if (mask_we) begin
                mask_q <= mask_wdata & MASKABLE;
            end

            if (exc_req) begin
                exc_ret_q <= exc_service ? exc_next_pc : exc_pc;
            end

            if (do_ret) begin
                act_q[act_min] <= 1'b0;
                redir_addr     <= ret_addr;
                redir_lvl      <= act_min;
            end else if (do_take) begin
                act_q[pick.lvl] <= 1'b1;
                redir_addr      <= vec_q[pick.lvl];
                redir_lvl       <= pick.lvl;
                case (cls_of(pick.lvl))
                    RC_EMU:  rete_q <= cur_pc;
                    RC_NMI:  retn_q <= cur_pc;
                    RC_EXC:  retx_q <= exc_ret_q;
                    default: if (pick.lvl != LVL_RST) reti_q <= cur_pc;
                endcase
            end
        end
    end

    assign in_service = act_q;
    assign supervisor = |act_q;

endmodule

// File: rtl/nest_evt_chk.sv
module nest_evt_chk (
    input logic        clk,
    input logic        rst,
    input logic        rtn_req,
    input logic        redir_valid,
    input logic [3:0]  redir_lvl,
    input logic [15:0] in_service,
    input logic        supervisor,
    input logic [15:0] mask_q
);

    logic [15:0] mask_prev, act_prev;
    logic        ret_prev;

    always_ff @(posedge clk) begin
        mask_prev <= mask_q;
        act_prev  <= in_service;
        ret_prev  <= rtn_req && (|in_service);
    end

    // R3: a take on a maskable level needs its enable bit.
    a_r3_masked_not_taken: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !ret_prev && redir_lvl >= 4'd5) |-> mask_prev[redir_lvl]);

    // R4: the reserved level never enters service.
    a_r4_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        !in_service[4]);

    // R5: a newly serviced level outranks every level already in service.
    a_r5_nest_order: assert property (@(posedge clk) disable iff (rst)
        (|(in_service & ~act_prev)) |->
            (redir_valid &&
             (act_prev == 16'h0 ||
              (in_service & ~act_prev) < (act_prev & (~act_prev + 16'h1)))));

    // R6: a return drops exactly one in-service level.
    a_r6_return_pops_one: assert property (@(posedge clk) disable iff (rst)
        ret_prev |->
            (redir_valid && $countones(in_service) == $countones(act_prev) - 1));

    // R11: supervisor only rises together with a redirect.
    a_r11_super_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(supervisor) |-> redir_valid);

endmodule

bind nest_evt_ctrl nest_evt_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .rtn_req     (rtn_req),
    .redir_valid (redir_valid),
    .redir_lvl   (redir_lvl),
    .in_service  (in_service),
    .supervisor  (supervisor),
    .mask_q      (mask_q)
);

// File: tb/test_nest_evt_ctrl.sv
module test_nest_evt_ctrl;

    localparam int AW   = 16;
    localparam int NSRC = 24;
    localparam int SW   = $clog2(NSRC);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     core_req = '0;
    logic [NSRC-1:0] sys_req = '0;
    logic            route_we = 1'b0;
    logic [SW-1:0]   route_src = '0;
    logic [3:0]      route_gp = '0;
    logic            mask_we = 1'b0;
    logic [15:0]     mask_wdata = '0;
    logic            vec_we = 1'b0;
    logic [3:0]      vec_lvl = '0;
    logic [AW-1:0]   vec_wdata = '0;
    logic            raise_req = 1'b0;
    logic [3:0]      raise_lvl = '0;
    logic            exc_req = 1'b0;
    logic            exc_service = 1'b0;
    logic [AW-1:0]   exc_pc = '0;
    logic [AW-1:0]   exc_next_pc = '0;
    logic [AW-1:0]   cur_pc = '0;
    logic            rtn_req = 1'b0;
    logic            redir_valid;
    logic [AW-1:0]   redir_addr;
    logic [3:0]      redir_lvl;
    logic [15:0]     in_service;
    logic            supervisor;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    nest_evt_ctrl #(.AW(AW), .NUM_SRC(NSRC)) i_nest_evt_ctrl (
        .clk, .rst, .core_req, .sys_req, .route_we, .route_src, .route_gp,
        .mask_we, .mask_wdata, .vec_we, .vec_lvl, .vec_wdata, .raise_req,
        .raise_lvl, .exc_req, .exc_service, .exc_pc, .exc_next_pc, .cur_pc,
        .rtn_req, .redir_valid, .redir_addr, .redir_lvl, .in_service,
        .supervisor
    );

    // Stimulus table: {kind (0 core, 1 system, 2 raise), index, expected level}
    localparam int NT = 14;
    localparam int TBL [NT][3] = '{
        '{0,  0,  0}, '{0,  2,  2}, '{0,  5,  5}, '{0,  6,  6},
        '{1,  0,  7}, '{1,  3,  7}, '{1,  7,  8}, '{1, 10,  9},
        '{1, 14, 10}, '{1, 17, 11}, '{1, 20, 12}, '{1, 23, 13},
        '{2,  9,  9}, '{2, 15, 15}
    };

    function automatic logic [AW-1:0] vexp(int l);
        return AW'(16'h1000 + l * 32);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: drive one cycle of request, return after that cycle.
    task automatic stim(input int kind, input int idx);
        case (kind)
            0:       core_req[idx] = 1'b1;
            1:       sys_req[idx]  = 1'b1;
            default: begin raise_req = 1'b1; raise_lvl = 4'(idx); end
        endcase
        @(negedge clk);
        core_req  = '0;
        sys_req   = '0;
        raise_req = 1'b0;
    endtask

    task automatic do_rtn;
        rtn_req = 1'b1;
        @(negedge clk);
        rtn_req = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 redir_valid", 32'(redir_valid), 32'd0);
        chk("R1 in_service", 32'(in_service), 32'd0);
        chk("R1 supervisor", 32'(supervisor), 32'd0);

        for (int l = 0; l < 16; l++) begin
            vec_we    = 1'b1;
            vec_lvl   = 4'(l);
            vec_wdata = vexp(l);
            @(negedge clk);
        end
        vec_we = 1'b0;

        // R1/R3: level 5 is masked out of reset, so the request stays pending
        stim(0, 5);
        @(negedge clk);
        chk("R1 masked after reset", 32'(redir_valid), 32'd0);
        mask_we    = 1'b1;
        mask_wdata = 16'hFFE0;
        @(negedge clk);
        mask_we = 1'b0;
        chk("R3 no take on enabling edge", 32'(redir_valid), 32'd0);
        @(negedge clk);
        chk("R3 pending taken after enable", 32'(redir_valid), 32'd1);
        chk("R3 level", 32'(redir_lvl), 32'd5);
        do_rtn();

        // R2/R6/R9/R10/R11: table walk
        for (int n = 0; n < NT; n++) begin
            cur_pc = AW'(16'h4000 + n * 4);
            stim(TBL[n][0], TBL[n][1]);
            @(negedge clk);
            chk("R2 take valid", 32'(redir_valid), 32'd1);
            chk("R2 R9 R10 level", 32'(redir_lvl), 32'(TBL[n][2]));
            chk("R2 vector", 32'(redir_addr), 32'(vexp(TBL[n][2])));
            chk("R11 supervisor", 32'(supervisor), 32'd1);
            do_rtn();
            chk("R6 return valid", 32'(redir_valid), 32'd1);
            chk("R6 R7 return addr", 32'(redir_addr), 32'(cur_pc));
            chk("R6 in_service cleared", 32'(in_service), 32'd0);
            chk("R11 supervisor low", 32'(supervisor), 32'd0);
        end

        // R4: ignored requests
        stim(0, 4);
        @(negedge clk);
        chk("R4 level4 core", 32'(redir_valid), 32'd0);
        stim(0, 3);
        @(negedge clk);
        chk("R4 core bit3", 32'(redir_valid), 32'd0);
        stim(2, 4);
        @(negedge clk);
        chk("R4 raise 4", 32'(redir_valid), 32'd0);
        stim(2, 3);
        @(negedge clk);
        chk("R4 raise 3", 32'(redir_valid), 32'd0);
        chk("R4 in_service", 32'(in_service), 32'd0);

        // R6 ignored when nothing is in service
        do_rtn();
        chk("R6 idle return ignored", 32'(redir_valid), 32'd0);

        // R2 same-cycle priority, R5 nesting
        cur_pc      = 16'h4800;
        core_req[6] = 1'b1;
        raise_req   = 1'b1;
        raise_lvl   = 4'd12;
        @(negedge clk);
        core_req  = '0;
        raise_req = 1'b0;
        @(negedge clk);
        chk("R2 priority level", 32'(redir_lvl), 32'd6);
        @(negedge clk);
        chk("R5 lower priority deferred", 32'(redir_valid), 32'd0);
        cur_pc = 16'h5000;
        stim(0, 2);
        @(negedge clk);
        chk("R5 preempt", 32'(redir_lvl), 32'd2);
        chk("R5 in_service nested", 32'(in_service), 32'h0044);
        do_rtn();
        chk("R6 nmi return addr", 32'(redir_addr), 32'h5000);
        chk("R6 in_service after pop", 32'(in_service), 32'h0040);
        @(negedge clk);
        chk("R5 still deferred", 32'(redir_valid), 32'd0);
        do_rtn();
        chk("R6 interrupt return addr", 32'(redir_addr), 32'h4800);
        @(negedge clk);
        chk("R5 deferred now taken", 32'(redir_lvl), 32'd12);
        chk("R5 deferred valid", 32'(redir_valid), 32'd1);
        do_rtn();

        // R8: service and error exceptions
        exc_req     = 1'b1;
        exc_service = 1'b1;
        exc_pc      = 16'h0200;
        exc_next_pc = 16'h0204;
        @(negedge clk);
        exc_req = 1'b0;
        exc_pc  = 16'hFFF0;
        @(negedge clk);
        chk("R8 exception level", 32'(redir_lvl), 32'd3);
        chk("R8 exception vector", 32'(redir_addr), 32'(vexp(3)));
        do_rtn();
        chk("R8 service return", 32'(redir_addr), 32'h0204);
        exc_req     = 1'b1;
        exc_service = 1'b0;
        exc_pc      = 16'h0300;
        exc_next_pc = 16'h0302;
        @(negedge clk);
        exc_req = 1'b0;
        @(negedge clk);
        do_rtn();
        chk("R8 error return", 32'(redir_addr), 32'h0300);

        // R7: level 1 captures nothing
        cur_pc = 16'h7000;
        stim(2, 7);
        @(negedge clk);
        cur_pc = 16'h7100;
        stim(0, 1);
        @(negedge clk);
        chk("R7 reset level taken", 32'(redir_lvl), 32'd1);
        do_rtn();
        chk("R7 reset return keeps interrupt reg", 32'(redir_addr), 32'h7000);
        do_rtn();
        chk("R7 outer return", 32'(redir_addr), 32'h7000);

        // R9: reprogram routing
        route_we  = 1'b1;
        route_src = SW'(5);
        route_gp  = 4'd2;
        @(negedge clk);
        route_src = SW'(6);
        route_gp  = 4'd12;
        @(negedge clk);
        route_we = 1'b0;
        stim(1, 5);
        @(negedge clk);
        chk("R9 rerouted level", 32'(redir_lvl), 32'd9);
        do_rtn();
        stim(1, 6);
        @(negedge clk);
        chk("R9 disconnected source", 32'(redir_valid), 32'd0);
        chk("R9 disconnected in_service", 32'(in_service), 32'd0);

        finish_run();
    end

endmodule